// File: doc/BRIEF.md
# Dual-Mode Host Register Access Port

This block is the slave end of an asynchronous parallel host bus. An external host uses it to read and write a register file that sits in the system clock domain. Two static strap inputs set the bus style. `proto_sel` picks between two access styles. In the first, one strobe works with a direction line. In the second, there are separate active-low read and write strobes. `mux_sel` picks between a shared address/data bus, where the address is latched with an address strobe, and separate address and data pins.

Every host pin goes through a two-stage synchronizer. Edges are detected on the synchronized copies. Each host access then becomes exactly one single-cycle `reg_rd` or `reg_wr` request, with address and write data. The register file answers a read on `reg_rdata` in the request cycle. The block holds that value on `bus_out` and raises `bus_oe` while the host keeps chip select and the read strobe asserted. Two pins carry meaning that depends on the style. `strb_n` is the data strobe in one style and the read strobe in the other. `dir_wr` is the read/write direction in one style and the active-low write strobe in the other.

Top module: `hostbus_slave`

## Requirements
- R1: With `proto_sel`=0 and `mux_sel`=0, a falling `strb_n` while `cs_n` is low and `dir_wr` is high (read) gives one `reg_rd` pulse whose `reg_addr` is the value on `addr` at that edge.
- R2: With `proto_sel`=0, a falling `strb_n` while `cs_n` is low and `dir_wr` is low starts a write. The address is taken at that falling edge. One `reg_wr` pulse follows when `strb_n` rises again, and `reg_wdata` is the value on `bus_in` at that rising edge.
- R3: A strobe edge seen while `cs_n` is high starts no access. No `reg_rd` or `reg_wr` is produced and the register contents stay unchanged.
- R4: With `proto_sel`=0 and `mux_sel`=1, the access address is the value on `bus_in` at the last falling edge of `ale_n` (address strobe), and not the `addr` pins.
- R5: With `proto_sel`=1, `strb_n` (read strobe) falling while `cs_n` is low and `dir_wr` (write strobe) is high gives one `reg_rd` pulse.
- R6: With `proto_sel`=1, `dir_wr` falling while `cs_n` is low and `strb_n` is high starts a write. One `reg_wr` pulse follows when `dir_wr` rises with `strb_n` still high, and it carries the value on `bus_in` at that rising edge.
- R7: With `proto_sel`=1, `strb_n` and `dir_wr` both low is illegal. Entering that state starts no access, and a write already in progress is dropped without a `reg_wr`.
- R8: With `proto_sel`=1 and `mux_sel`=1, a falling `ale_n` latches the address from `bus_in`.
- R9: `bus_oe` is high only after a read has started, and only while the synchronized `cs_n` and read strobe are both low. It drops in the first clock cycle in which either one is seen high. While `bus_oe` is high, `bus_out` holds the `reg_rdata` value sampled in the `reg_rd` cycle.
- R10: With `cs_n` and `strb_n` switching together (tied), reads and writes decode as they do with separate pins.
- R11: Each access gives exactly one request pulse, one cycle long, and `reg_rd` and `reg_wr` are never high together.
- R12: A request is asserted in the clock cycle that follows the second rising clock edge at which the triggering pin level is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proto_sel | input | 1 | Strap: 0 strobe plus direction, 1 separate read/write strobes |
| mux_sel | input | 1 | Strap: 1 shared address/data bus, 0 separate buses |
| cs_n | input | 1 | Chip select, active low |
| strb_n | input | 1 | Data strobe (style 0) or read strobe (style 1), active low |
| dir_wr | input | 1 | Direction, high = read (style 0), or write strobe, active low (style 1) |
| ale_n | input | 1 | Address strobe; its falling edge latches the address in shared-bus mode |
| addr | input | AW | Address pins for separate-bus mode |
| bus_in | input | DW | Data bus input from the pad; carries the address in shared-bus mode |
| bus_out | output | DW | Read data to the pad |
| bus_oe | output | 1 | Pad output enable for the data bus |
| reg_rd | output | 1 | Register read request, one cycle |
| reg_wr | output | 1 | Register write request, one cycle |
| reg_addr | output | AW | Request address |
| reg_wdata | output | DW | Write data, valid with `reg_wr` |
| reg_rdata | input | DW | Register read data, sampled in the `reg_rd` cycle |

## Verification
The assertions assume that the straps stay constant during an access. They also assume that the host holds every pin stable for several clock periods around each edge, so that every level reaches the second synchronizer stage before the next change. The stimulus changes pins only a few nanoseconds after a rising clock edge. It holds each strobe, address and data phase for at least three clocks and changes the straps only while the bus is idle. In the illegal-combination cases, both strobes go low in the same clock cycle or one after the other, because the assertions on write legality rely on the write strobe being seen released when a write completes.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          proto_sel,
  input  logic          mux_sel,
  input  logic          cs_n,
  input  logic          strb_n,
  input  logic          dir_wr,
  input  logic          ale_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [AW-1:0] reg_addr,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);
  localparam int NC = 6;
  localparam int SW = NC + AW + DW;
  localparam logic [SW-1:0] IDLE = {2'b00, 4'b1111, {(AW+DW){1'b0}}};

  logic [SW-1:0] raw, st1, st2;
  logic [3:0]    prv;

  assign raw = {proto_sel, mux_sel, cs_n, strb_n, dir_wr, ale_n, addr, bus_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st1 <= IDLE;
      st2 <= IDLE;
      prv <= 4'b1111;
    end else begin
      st1 <= raw;
      st2 <= st1;
      prv <= st2[SW-3 -: 4];
    end
  end

  logic          m_proto, m_mux, m_cs_n, m_strb, m_dir, m_ale;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_din;
  assign {m_proto, m_mux, m_cs_n, m_strb, m_dir, m_ale, m_addr, m_din} = st2;

  logic sel, strb_fall, strb_rise, dir_fall, dir_rise, ale_fall, both_low;
  assign sel       = !m_cs_n;
  assign strb_fall =  prv[2] && !m_strb;
  assign strb_rise = !prv[2] &&  m_strb;
  assign dir_fall  =  prv[1] && !m_dir;
  assign dir_rise  = !prv[1] &&  m_dir;
  assign ale_fall  =  prv[0] && !m_ale;
  assign both_low  = m_proto && !m_strb && !m_dir;

  logic [AW-1:0] bus_addr;
  generate
    if (AW <= DW) begin : g_narrow
      assign bus_addr = m_din[AW-1:0];
    end else begin : g_wide
      assign bus_addr = {{(AW-DW){1'b0}}, m_din};
    end
  endgenerate

  logic [AW-1:0] lat_addr, acc_addr, cur_addr;
  logic [DW-1:0] rd_hold;
  logic          wr_pend, rd_act;
  logic          rd_go, wr_go, wr_done;

  assign cur_addr = m_mux ? lat_addr : m_addr;
  assign rd_go    = strb_fall && sel && m_dir;
  assign wr_go    = m_proto ? (dir_fall && sel && m_strb) : (strb_fall && sel && !m_dir);
  assign wr_done  = wr_pend && (m_proto ? (dir_rise && m_strb) : strb_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_addr <= '0;
      acc_addr <= '0;
      rd_hold  <= '0;
      wr_pend  <= 1'b0;
      rd_act   <= 1'b0;
    end else begin
      if (m_mux && ale_fall) lat_addr <= bus_addr;
      if (rd_go || wr_go) acc_addr <= cur_addr;
      if (rd_go) begin
        rd_hold <= reg_rdata;
        rd_act  <= 1'b1;
      end else if (!sel || m_strb) begin
        rd_act  <= 1'b0;
      end
      if (wr_go) wr_pend <= 1'b1;
      else if (wr_done || both_low) wr_pend <= 1'b0;
    end
  end

  assign reg_rd    = rd_go;
  assign reg_wr    = wr_done;
  assign reg_addr  = rd_go ? cur_addr : acc_addr;
  assign reg_wdata = m_din;
  assign bus_out   = rd_hold;
  assign bus_oe    = rd_act && sel && !m_strb && (!m_proto || m_dir);

endmodule

module hostbus_slave_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          proto_sel,
  input logic          cs_n,
  input logic          strb_n,
  input logic          dir_wr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic          bus_oe,
  input logic [DW-1:0] bus_out
);
  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |=> !reg_rd); // R11
  AST_WR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) reg_wr |=> !reg_wr); // R11
  AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n) !(reg_rd && reg_wr)); // R11
  AST_RD_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n) reg_rd |-> !$past(cs_n, 2)); // R3
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!$past(cs_n, 2) && !$past(strb_n, 2))); // R9
  AST_OE_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && $past(bus_oe)) |-> $stable(bus_out)); // R9
  AST_WR_STROBE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && proto_sel) |-> ($past(dir_wr, 2) && $past(strb_n, 2))); // R6
endmodule

bind hostbus_slave hostbus_slave_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .cs_n(cs_n), .strb_n(strb_n),
  .dir_wr(dir_wr), .reg_rd(reg_rd), .reg_wr(reg_wr), .bus_oe(bus_oe), .bus_out(bus_out)
);

// File: tb/sim_hostbus_slave.sv
module sim_hostbus_slave;
  logic clk = 0, rst_n = 0;
  logic proto_sel = 0, mux_sel = 0, cs_n = 1, strb_n = 1, dir_wr = 1, ale_n = 1;
  logic [7:0] addr = 0, bus_in = 0;
  logic [7:0] bus_out, reg_addr, reg_wdata, reg_rdata;
  logic bus_oe, reg_rd, reg_wr;

  always #5 clk = ~clk;

  hostbus_slave #(.AW(8), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .proto_sel(proto_sel), .mux_sel(mux_sel), .cs_n(cs_n),
    .strb_n(strb_n), .dir_wr(dir_wr), .ale_n(ale_n), .addr(addr), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  logic [7:0] tmem [256];
  logic [7:0] mmem [256];
  assign reg_rdata = tmem[reg_addr];
  always @(posedge clk) if (reg_wr) tmem[reg_addr] <= reg_wdata;

  int errors = 0, checks = 0;
  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: pin history through two sampling stages
  int q1[10], q2[10], pv[10];
  int mlat, macc, mhold, mpend, mact;
  int e_rd, e_wr, e_addr, e_oe;

  function automatic void events();
    int sel, sf, sr, df, dr, ca;
    sel = (q2[2] == 0);
    sf = pv[3] && !q2[3]; sr = !pv[3] && q2[3];
    df = pv[4] && !q2[4]; dr = !pv[4] && q2[4];
    ca = q2[1] ? mlat : q2[6];
    e_rd = sf && sel && q2[4];
    if (q2[0]) e_wr = mpend && dr && q2[3];
    else       e_wr = mpend && sr;
    e_addr = e_rd ? ca : macc;
    e_oe = mact && sel && !q2[3] && (!q2[0] || q2[4]);
  endfunction

  task automatic reset_model();
    foreach (q1[i]) begin q1[i] = 0; q2[i] = 0; pv[i] = 0; end
    q1[2] = 1; q1[3] = 1; q1[4] = 1; q1[5] = 1;
    q2 = q1; pv = q1;
    mlat = 0; macc = 0; mhold = 0; mpend = 0; mact = 0;
  endtask

  always @(posedge clk) begin
    if (!rst_n) reset_model();
    else begin
      int sel, sf, df, wgo, ca;
      events();
      sel = (q2[2] == 0);
      sf = pv[3] && !q2[3]; df = pv[4] && !q2[4];
      ca = q2[1] ? mlat : q2[6];
      wgo = q2[0] ? (df && sel && q2[3]) : (sf && sel && !q2[4]);
      if (e_wr) mmem[macc] = q2[7][7:0];
      if (e_rd) begin mhold = mmem[ca]; mact = 1; end
      else if (!sel || q2[3]) mact = 0;
      if (e_rd || wgo) macc = ca;
      if (wgo) mpend = 1;
      else if (e_wr || (q2[0] && !q2[3] && !q2[4])) mpend = 0;
      if (q2[1] && pv[5] && !q2[5]) mlat = q2[7];
      pv = q2; q2 = q1;
      q1[0] = proto_sel; q1[1] = mux_sel; q1[2] = cs_n; q1[3] = strb_n;
      q1[4] = dir_wr; q1[5] = ale_n; q1[6] = addr; q1[7] = bus_in;
    end
  end

  int seen_rd = 0, seen_wr = 0, last_out = -1;
  always @(negedge clk) if (rst_n) begin
    events();
    chk(reg_rd == e_rd, "R12 reg_rd timing", reg_rd, e_rd);
    chk(reg_wr == e_wr, "R12 reg_wr timing", reg_wr, e_wr);
    if (e_rd || e_wr) chk(reg_addr == e_addr, "R1 reg_addr", reg_addr, e_addr);
    if (e_wr) chk(reg_wdata == q2[7], "R2 reg_wdata", reg_wdata, q2[7]);
    chk(bus_oe == e_oe, "R9 bus_oe", bus_oe, e_oe);
    if (e_oe) chk(bus_out == mhold, "R9 bus_out", bus_out, mhold);
    if (reg_rd) seen_rd++;
    if (reg_wr) seen_wr++;
    if (bus_oe) last_out = bus_out;
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic access(bit wr, logic [7:0] a, logic [7:0] d, bit tied, bit csoff);
    bit use_strb;
    use_strb = !proto_sel || !wr;
    if (mux_sel) begin
      bus_in = a; step(1); ale_n = 0; step(3); ale_n = 1; step(3);
    end else addr = a;
    bus_in = d;
    dir_wr = proto_sel ? 1'b1 : !wr;
    step(2);
    if (!tied) begin cs_n = csoff; step(2); end
    else cs_n = csoff;
    if (use_strb) strb_n = 0; else dir_wr = 0;
    step(5);
    if (use_strb) strb_n = 1; else dir_wr = 1;
    if (tied) cs_n = 1;
    step(3);
    cs_n = 1; dir_wr = 1;
    step(3);
  endtask

  task automatic expect_acc(string tag, int b_rd, int b_wr, int n_rd, int n_wr);
    chk(seen_rd - b_rd == n_rd, {tag, " R11 read count"}, seen_rd - b_rd, n_rd);
    chk(seen_wr - b_wr == n_wr, {tag, " R11 write count"}, seen_wr - b_wr, n_wr);
  endtask

  task automatic wr_rd(string tag, logic [7:0] a, logic [7:0] d, bit tied);
    int br, bw;
    br = seen_rd; bw = seen_wr;
    access(1, a, d, tied, 0);
    last_out = -1;
    access(0, a, 8'h00, tied, 0);
    expect_acc(tag, br, bw, 1, 1);
    chk(last_out == d, {tag, " read back"}, last_out, d);
  endtask

  task automatic set_mode(bit p, bit m);
    proto_sel = p; mux_sel = m; step(4);
  endtask

  initial begin
    int br, bw;
    for (int i = 0; i < 256; i++) begin tmem[i] = i[7:0] ^ 8'h5A; mmem[i] = i[7:0] ^ 8'h5A; end
    step(5);
    chk(!reg_rd && !reg_wr && !bus_oe, "R11 reset outputs idle", {reg_rd, reg_wr, bus_oe}, 0);
    rst_n = 1; step(4);

    set_mode(0, 0);
    wr_rd("R1 R2 strobe-dir separate", 8'h12, 8'hA5, 0);
    br = seen_rd; bw = seen_wr;
    access(1, 8'h12, 8'h00, 0, 1);
    access(0, 8'h12, 8'h00, 0, 1);
    expect_acc("R3 chip select high", br, bw, 0, 0);
    last_out = -1; access(0, 8'h12, 8'h00, 0, 0);
    chk(last_out == 8'hA5, "R3 register unchanged", last_out, 8'hA5);
    wr_rd("R10 tied select and strobe", 8'h30, 8'h3C, 1);

    set_mode(0, 1);
    addr = 8'hFF;
    wr_rd("R4 shared bus address strobe", 8'h44, 8'h77, 0);

    set_mode(1, 0);
    wr_rd("R5 R6 split strobes", 8'h55, 8'h99, 0);
    br = seen_rd; bw = seen_wr;
    addr = 8'h55; bus_in = 8'hEE; cs_n = 0; step(2);
    strb_n = 0; dir_wr = 0; step(5); strb_n = 1; dir_wr = 1; step(4);
    dir_wr = 0; step(4); strb_n = 0; step(4); dir_wr = 1; step(1); strb_n = 1; step(4);
    cs_n = 1; step(3);
    expect_acc("R7 both strobes low", br, bw, 0, 0);
    last_out = -1; access(0, 8'h55, 8'h00, 0, 0);
    chk(last_out == 8'h99, "R7 register unchanged", last_out, 8'h99);

    set_mode(1, 1);
    addr = 8'h00;
    wr_rd("R8 split strobes shared bus", 8'h66, 8'h12, 0);
    step(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule